// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This peripheral guards a system against software that stops running. Software programs an 8-bit timeout and sets a sticky enable bit. From then on a down-counter loses one step for each pulse on a slow timebase input, which is nominally 2 Hz, so one step is 0.5 s. If the counter reaches zero, the block records a timeout cause and raises a reset request that stays high until the system reset. Software keeps the counter alive by writing two key words in a row to a service register. Any other write in between breaks the pair. Software can also request a reset directly through an active-low bit in the control register.

A second counter can give an early warning. When the main counter is loaded, and the interrupt is enabled, this counter starts from the remaining count minus a programmed margin. It starts only if that difference is positive. When it runs out, it sets an interrupt status flag and drives the interrupt output. Writing 1 to the flag clears it. The interrupt enable and the margin can be written once after reset; further writes to them are ignored. The bus is a single-cycle 16-bit write strobe with a combinational read port. Only even (16-bit aligned) offsets decode.

Three state machines make up the block:
- **Main timer.**
  - `TMR_IDLE` goes to `TMR_RUN` on a load while the block is enabled.
  - `TMR_RUN` stays in `TMR_RUN` on a reload or on a tick with more than one step left.
  - `TMR_RUN` goes to `TMR_EXPIRED` on a tick with one step left.
  - `TMR_EXPIRED` is terminal until reset.
- **Service sequencer.**
  - `SVC_IDLE` goes to `SVC_ARMED` on a first-key write.
  - `SVC_ARMED` completes the pair on a second-key write and returns to `SVC_IDLE`.
  - `SVC_ARMED` stays armed on another first-key write.
  - `SVC_ARMED` returns to `SVC_IDLE` on any other service write.
- **Early-warning timer.**
  - Any arm event enters `PT_RUN` if the margin test passes, and `PT_OFF` otherwise.
  - `PT_RUN` goes to `PT_FIRED` on the tick that empties it.
  - `PT_FIRED` and `PT_OFF` hold until the next arm.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x0030, reset status (0x4) reads 0x0000, interrupt control (0x6) reads 0x0004, misc (0x8) reads 0x0001, service (0x2) reads 0x0000, and irq and rst_req are low.
- R2: Control bits 15:8 hold the timeout n, and bit 2 is the enable. A control write with bit 2 set loads the counter with n+1. rst_req stays low through n ticks and rises after tick n+1. Reset status then reads 0x0002 (bit 1 = timeout cause).
- R3: While the enable bit is 0, ticks have no effect: rst_req stays low and reset status stays 0.
- R4: Writing 0x5555 and then 0xAAAA to offset 0x2 reloads the counter with n+1. If any other service write comes between the two, the pair is broken and nothing is reloaded.
- R5: Once the enable bit reads 1, it cannot be cleared, and the timeout field is frozen. A control write while enabled still updates bit 5 and reloads the counter.
- R6: A control write with bit 4 = 0 sets reset status to 0x0001 (bit 0 = software cause) and raises rst_req on the next cycle. This holds whatever bit 5 is. Bit 4 always reads 1. Writes to the reset status register are ignored.
- R7: Interrupt control uses bit 15 as enable, bit 14 as status, and bits 7:0 as margin P. Each counter load with the enable set arms the early-warning counter with (n+1)-P, if that value is above 0. When it empties, bit 14 and irq go high. If n+1 <= P it never fires.
- R8: Writing 1 to bit 14 clears the status and irq. Bits 15 and 7:0 accept only the first write after reset.
- R9: Writes to odd offsets and unmapped offsets change nothing.
- R10: Misc bit 0 is read/write.
- R11: rst_req, once high, stays high until reset, and the main timer stops after expiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | One-cycle timebase pulse, one per period |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
A corrupted main-timer state shows up at rst_req: it rises one tick early or late, or it never rises. Each test counts ticks exactly so that an error of one period is caught on the tick it occurs. A service sequencer that drops or forgets its armed state shows up as an expiry, or a missing expiry, within the reload window after the broken or valid pair. A wrong early-warning count moves the irq edge by whole ticks. A lock that fails to hold shows up at once when the register is read back after the rejected write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int TMO_W  = 8;
    localparam int CNT_W  = TMO_W + 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] A_ICR  = 4'h6;
    localparam logic [ADDR_W-1:0] A_MISC = 4'h8;

    localparam logic [DATA_W-1:0] SVC_KEY_A = 16'h5555;
    localparam logic [DATA_W-1:0] SVC_KEY_B = 16'hAAAA;

    // control bit positions
    localparam int B_EN  = 2;
    localparam int B_SRS = 4;
    localparam int B_WDA = 5;
    // interrupt control bit positions
    localparam int B_IEN = 15;
    localparam int B_IST = 14;
    // reset status bit positions
    localparam int B_CSW  = 0;
    localparam int B_CTMO = 1;

    typedef enum logic [1:0] {TMR_IDLE, TMR_RUN, TMR_EXPIRED} tmr_state_t;
    typedef enum logic       {SVC_IDLE, SVC_ARMED}            svc_state_t;
    typedef enum logic [1:0] {PT_OFF, PT_RUN, PT_FIRED}       pt_state_t;
endpackage

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_done
);
    svc_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            SVC_IDLE:  if (svc_wr && svc_data == SVC_KEY_A) st_nx = SVC_ARMED;
            SVC_ARMED: if (svc_wr) st_nx = (svc_data == SVC_KEY_A) ? SVC_ARMED : SVC_IDLE;
            default:   st_nx = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SVC_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        svc_done = (st == SVC_ARMED) && svc_wr && (svc_data == SVC_KEY_B);
    end
endmodule

// File: rtl/wdog_tmr.sv
module wdog_tmr
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             enable,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire,
    output logic [CNT_W-1:0] count,
    output tmr_state_t       state_o
);
    tmr_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            TMR_IDLE: begin
                if (load && enable) begin
                    st_nx  = TMR_RUN;
                    cnt_nx = load_val;
                end
            end
            TMR_RUN: begin
                if (load) begin
                    cnt_nx = load_val;
                end else if (tick) begin
                    if (cnt == CNT_W'(1)) begin
                        st_nx  = TMR_EXPIRED;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt - CNT_W'(1);
                    end
                end
            end
            TMR_EXPIRED: st_nx = TMR_EXPIRED;
            default:     st_nx = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TMR_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        expire  = (st == TMR_RUN) && !load && tick && (cnt == CNT_W'(1));
        count   = cnt;
        state_o = st;
    end
endmodule

// File: rtl/wdog_pretimer.sv
module wdog_pretimer
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             allow,
    input  logic [CNT_W-1:0] base,
    input  logic [TMO_W-1:0] margin,
    output logic             fire,
    output logic [CNT_W-1:0] count,
    output pt_state_t        state_o
);
    localparam int PAD_W = CNT_W - TMO_W;

    pt_state_t        st, st_nx;
    logic [CNT_W-1:0] pc, pc_nx;
    logic [CNT_W-1:0] margin_ext;

    always_comb begin
        margin_ext = {{PAD_W{1'b0}}, margin};
        st_nx      = st;
        pc_nx      = pc;
        if (arm) begin
            if (allow && base > margin_ext) begin
                st_nx = PT_RUN;
                pc_nx = base - margin_ext;
            end else begin
                st_nx = PT_OFF;
                pc_nx = '0;
            end
        end else begin
            unique case (st)
                PT_OFF:   st_nx = PT_OFF;
                PT_RUN: begin
                    if (tick) begin
                        if (pc == CNT_W'(1)) begin
                            st_nx = PT_FIRED;
                            pc_nx = '0;
                        end else begin
                            pc_nx = pc - CNT_W'(1);
                        end
                    end
                end
                PT_FIRED: st_nx = PT_FIRED;
                default:  st_nx = PT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PT_OFF;
            pc <= '0;
        end else begin
            st <= st_nx;
            pc <= pc_nx;
        end
    end

    always_comb begin
        fire    = (st == PT_RUN) && !arm && tick && (pc == CNT_W'(1));
        count   = pc;
        state_o = st;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [TMO_W-1:0] PT_DEFAULT = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              svc_done,
    input  logic              expire,
    input  logic              pt_fire,
    output logic              wd_en,
    output logic [TMO_W-1:0]  tmo,
    output logic              irq_en,
    output logic [TMO_W-1:0]  margin,
    output logic              irq,
    output logic              rst_req,
    output logic              reload,
    output logic              icr_rearm,
    output logic              sw_rst
);
    logic       wr_ctrl, wr_icr, wr_misc;
    logic       wda, ist, ilock, pde;
    logic [1:0] cause;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_icr  = bus_wr && (bus_addr == A_ICR);
        wr_misc = bus_wr && (bus_addr == A_MISC);
        sw_rst  = wr_ctrl && !bus_wdata[B_SRS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo       <= '0;
            wd_en     <= 1'b0;
            wda       <= 1'b1;
            cause     <= '0;
            rst_req   <= 1'b0;
            irq_en    <= 1'b0;
            margin    <= PT_DEFAULT;
            ist       <= 1'b0;
            ilock     <= 1'b0;
            pde       <= 1'b1;
            reload    <= 1'b0;
            icr_rearm <= 1'b0;
        end else begin
            reload    <= wr_ctrl || svc_done;
            icr_rearm <= wr_icr;
            if (wr_ctrl) begin
                if (!wd_en) begin
                    tmo   <= bus_wdata[DATA_W-1 -: TMO_W];
                    wd_en <= bus_wdata[B_EN];
                end
                wda <= bus_wdata[B_WDA];
            end
            if (sw_rst) begin
                cause   <= 2'b01 << B_CSW;
                rst_req <= 1'b1;
            end
            if (expire) begin
                cause   <= 2'b01 << B_CTMO;
                rst_req <= 1'b1;
            end
            if (wr_icr) begin
                if (!ilock) begin
                    irq_en <= bus_wdata[B_IEN];
                    margin <= bus_wdata[TMO_W-1:0];
                    ilock  <= 1'b1;
                end
                if (bus_wdata[B_IST]) ist <= 1'b0;
            end
            if (pt_fire) ist <= 1'b1;
            if (wr_misc) pde <= bus_wdata[0];
        end
    end

    always_comb begin
        irq       = ist;
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[DATA_W-1 -: TMO_W] = tmo;
                bus_rdata[B_WDA]             = wda;
                bus_rdata[B_SRS]             = 1'b1;
                bus_rdata[B_EN]              = wd_en;
            end
            A_STAT: bus_rdata[1:0] = cause;
            A_ICR: begin
                bus_rdata[B_IEN]     = irq_en;
                bus_rdata[B_IST]     = ist;
                bus_rdata[TMO_W-1:0] = margin;
            end
            A_MISC:  bus_rdata[0] = pde;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter logic [TMO_W-1:0] PT_DEFAULT = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic             wd_en, irq_en, reload, icr_rearm, sw_rst;
    logic             svc_wr, svc_done, expire, pt_fire, pt_arm, pt_allow;
    logic [TMO_W-1:0] tmo, margin;
    logic [CNT_W-1:0] load_val, tmr_cnt, pt_cnt, pt_base;
    tmr_state_t       tmr_state;
    pt_state_t        pt_state;

    always_comb begin
        svc_wr   = bus_wr && (bus_addr == A_SVC);
        load_val = {1'b0, tmo} + CNT_W'(1);
        pt_arm   = reload || icr_rearm;
        pt_base  = reload ? load_val : tmr_cnt;
        pt_allow = irq_en && wd_en && (tmr_state != TMR_EXPIRED);
    end

    wdog_regs #(.PT_DEFAULT(PT_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc_done(svc_done),
        .expire(expire), .pt_fire(pt_fire), .wd_en(wd_en), .tmo(tmo),
        .irq_en(irq_en), .margin(margin), .irq(irq), .rst_req(rst_req),
        .reload(reload), .icr_rearm(icr_rearm), .sw_rst(sw_rst)
    );

    wdog_svc_seq u_svc (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(bus_wdata),
        .svc_done(svc_done)
    );

    wdog_tmr u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(reload), .enable(wd_en),
        .load_val(load_val), .expire(expire), .count(tmr_cnt), .state_o(tmr_state)
    );

    wdog_pretimer u_pt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(pt_arm), .allow(pt_allow),
        .base(pt_base), .margin(margin), .fire(pt_fire), .count(pt_cnt),
        .state_o(pt_state)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             irq,
    input logic             wd_en,
    input logic             expire,
    input logic             sw_rst,
    input logic             pt_fire,
    input tmr_state_t       tmr_state,
    input logic [CNT_W-1:0] tmr_cnt,
    input pt_state_t        pt_state,
    input logic [CNT_W-1:0] pt_cnt
);
    // R11
    rst_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R11
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_state == TMR_EXPIRED |=> tmr_state == TMR_EXPIRED);
    // R5
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> wd_en);
    // R2
    rst_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(expire || sw_rst));
    // R2
    tmr_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_state == TMR_RUN |-> tmr_cnt != '0);
    // R3
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> tmr_state == TMR_IDLE);
    // R7
    pt_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pt_state == PT_RUN |-> pt_cnt != '0);
    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pt_fire));
endmodule

bind wdog_top wdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq), .wd_en(wd_en),
    .expire(expire), .sw_rst(sw_rst), .pt_fire(pt_fire), .tmr_state(tmr_state),
    .tmr_cnt(tmr_cnt), .pt_state(pt_state), .pt_cnt(pt_cnt)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, rst_req;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    wdog_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {4'h8, 16'h0000, 4'h8, 16'h0000},   // R10
        {4'h8, 16'h0001, 4'h8, 16'h0001},   // R10
        {4'h9, 16'h0000, 4'h8, 16'h0001},   // R9
        {4'h1, 16'h0000, 4'h0, 16'h0030},   // R9
        {4'h6, 16'h0107, 4'h6, 16'h0007},   // R8
        {4'h6, 16'h80FF, 4'h6, 16'h0007},   // R8
        {4'h0, 16'h0530, 4'h0, 16'h0530},   // R2
        {4'h0, 16'h0710, 4'h0, 16'h0710},   // R6
        {4'h0, 16'h0734, 4'h0, 16'h0734},   // R5
        {4'h0, 16'h0930, 4'h0, 16'h0734},   // R5
        {4'h4, 16'hFFFF, 4'h4, 16'h0000}    // R6
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R10";
            2, 3:    return "R9";
            4, 5:    return "R8";
            6:       return "R2";
            7, 10:   return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset values
        rd_chk("R1", 4'h0, 16'h0030);
        rd_chk("R1", 4'h2, 16'h0000);
        rd_chk("R1", 4'h4, 16'h0000);
        rd_chk("R1", 4'h6, 16'h0004);
        rd_chk("R1", 4'h8, 16'h0001);
        chk("R1", {15'b0, irq}, 16'h0);
        chk("R1", {15'b0, rst_req}, 16'h0);

        // R3 ticks while disabled
        ticks(5);
        chk("R3", {15'b0, rst_req}, 16'h0);
        rd_chk("R3", 4'h4, 16'h0000);

        // register vector table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][39:36], VEC[i][35:20]);
            rd_chk(vec_tag(i), VEC[i][19:16], VEC[i][15:0]);
        end
        chk("R9", {15'b0, rst_req}, 16'h0);

        // R2 timeout of n+1 periods, n=3
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3);
        chk("R2", {15'b0, rst_req}, 16'h0);
        ticks(1);
        chk("R2", {15'b0, rst_req}, 16'h1);
        rd_chk("R2", 4'h4, 16'h0002);
        // R11 sticky after expiry, service has no effect
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(3);
        chk("R11", {15'b0, rst_req}, 16'h1);
        rd_chk("R11", 4'h4, 16'h0002);

        // R4 service pair reloads; broken pair does not
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(3);
        chk("R4", {15'b0, rst_req}, 16'h0);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        ticks(1);
        chk("R4", {15'b0, rst_req}, 16'h1);

        // R6 software reset request
        do_reset();
        wr(4'h0, 16'h0020);
        chk("R6", {15'b0, rst_req}, 16'h1);
        rd_chk("R6", 4'h4, 16'h0001);
        rd_chk("R6", 4'h0, 16'h0030);
        do_reset();
        wr(4'h0, 16'h0000);
        chk("R6", {15'b0, rst_req}, 16'h1);
        rd_chk("R6", 4'h4, 16'h0001);

        // R7 early warning: n=9, P=4 -> fires after 6 ticks
        do_reset();
        wr(4'h6, 16'h8004);
        wr(4'h0, 16'h0934);
        ticks(5);
        chk("R7", {15'b0, irq}, 16'h0);
        ticks(1);
        chk("R7", {15'b0, irq}, 16'h1);
        rd_chk("R7", 4'h6, 16'hC004);
        // R8 write-one-to-clear, locked fields kept
        wr(4'h6, 16'h4000);
        chk("R8", {15'b0, irq}, 16'h0);
        rd_chk("R8", 4'h6, 16'h8004);
        chk("R8", {15'b0, rst_req}, 16'h0);

        // R7 margin not below count: never fires
        do_reset();
        wr(4'h6, 16'h800A);
        wr(4'h0, 16'h0934);
        ticks(10);
        chk("R7", {15'b0, irq}, 16'h0);
        chk("R7", {15'b0, rst_req}, 16'h1);

        finish_run();
    end
endmodule